// File: doc/BRIEF.md
# Dual-Length Micro-op Replay Loop

This block works beside one instruction scheduler. It recirculates micro-operations that were dispatched speculatively and were later found to need another try. Every micro-op on the dispatch output carries a tag and a replay count. It then travels through a fixed check pipeline. A fast check, sampled two cycles after dispatch, can divert the micro-op into a short delay line. A late check, sampled four cycles after dispatch, can divert it into a long delay line. A micro-op that clears both checks is offered on the retire output. Micro-ops coming back from either delay line take the dispatch slot ahead of new issue, and new issue is held off through `new_ready`.

A parameter, `SINGLE_LOOP`, folds the two paths into one longer loop. In that mode every rejection, from either check, comes back after 18 cycles. The block shares no state with anything else, so one copy can sit beside each scheduler. A micro-op can go round any number of times until it clears both checks.

Top module: `uop_replay_loop`

## Requirements
- R1: In dual mode, a micro-op that the fast check rejects (`fast_err` high two cycles after its dispatch) appears again on the dispatch output exactly 7 cycles after that dispatch. The only exception is the one-cycle delay of R7.
- R2: In dual mode, a micro-op that the late check rejects (`late_err` high four cycles after its dispatch) and that the fast check did not reject appears again on the dispatch output exactly 12 cycles after that dispatch.
- R3: A rejected micro-op never appears on the retire output. A micro-op flagged by both checks in dual mode goes round the short loop only and comes back once. `fast_err` and `late_err` have no effect in a cycle where no live micro-op is at that check stage.
- R4: With `SINGLE_LOOP` set, a micro-op rejected by either check, or by both, appears again on the dispatch output exactly 18 cycles after its dispatch.
- R5: A micro-op that clears both checks asserts `retire_valid`, with its tag and count, exactly four cycles after its dispatch. This happens once, in that cycle only.
- R6: In any cycle where a returning or held micro-op is present, it drives the dispatch output and `new_ready` is low. Otherwise `new_ready` is high and a new micro-op is dispatched in the same cycle as `new_valid`.
- R7: If both loops deliver in the same cycle, the long-loop micro-op is dispatched first. The short-loop micro-op is held in a one-entry skid register and is dispatched the next cycle.
- R8: A new micro-op is dispatched with count 0. Each rejection increments the count it returns with, and the count stops at its maximum, 2^CNT_W-1.
- R9: A synchronous active-high reset clears both delay lines, the check pipeline and the skid register. After reset, nothing returns and nothing retires until new micro-ops are dispatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| new_valid | input | 1 | A new micro-op is offered for issue |
| new_tag | input | TAG_W | Tag of the offered micro-op |
| new_ready | output | 1 | The offered micro-op is taken this cycle |
| fast_err | input | 1 | Fast check verdict for the micro-op dispatched two cycles earlier |
| late_err | input | 1 | Late check verdict for the micro-op dispatched four cycles earlier |
| disp_valid | output | 1 | A micro-op is dispatched this cycle |
| disp_tag | output | TAG_W | Tag of the dispatched micro-op |
| disp_cnt | output | CNT_W | Replay count of the dispatched micro-op |
| retire_valid | output | 1 | A micro-op has cleared both checks |
| retire_tag | output | TAG_W | Tag of the retiring micro-op |
| retire_cnt | output | CNT_W | Replay count of the retiring micro-op |

## Verification
The assertions assume that the error inputs never produce a cycle in which the skid register is still full while both loops deliver. In other words, a double arrival is never followed at once by another arrival. The bench keeps its own schedule of future returns. It raises a rejection only if the return slot it would claim keeps that pattern out. Micro-ops with one chosen tag are always pushed to reject, so the count reaches saturation. Both loops also collide on purpose, and the error inputs are toggled at random when no micro-op is at the check stage.

// File: rtl/uop_replay_pkg.sv
package uop_replay_pkg;

  typedef enum logic [1:0] {
    SRC_NEW   = 2'd0,
    SRC_SHORT = 2'd1,
    SRC_LONG  = 2'd2,
    SRC_SKID  = 2'd3
  } disp_src_e;

  // Delay-line length that makes a loop total equal to the given latency,
  // counted from the dispatch cycle, when entry happens at a check stage.
  function automatic int line_depth(input int total_lat, input int check_stage);
    return total_lat - check_stage;
  endfunction

endpackage

// File: rtl/uop_delay_line.sv
module uop_delay_line #(
  parameter int DEPTH = 5,
  parameter int W     = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);

  logic [DEPTH-1:0] vld_q;
  logic [W-1:0]     dat_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= {vld_q[DEPTH-2:0], in_v};
    dat_q[0] <= in_d;
    for (int i = 1; i < DEPTH; i++) dat_q[i] <= dat_q[i-1];
  end

  assign out_v = vld_q[DEPTH-1];
  assign out_d = dat_q[DEPTH-1];

endmodule

// File: rtl/uop_check_pipe.sv
module uop_check_pipe #(
  parameter int TAG_W       = 8,
  parameter int CNT_W       = 3,
  parameter int FAST_STG    = 2,
  parameter int LATE_STG    = 4,
  parameter int SINGLE_LOOP = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_v,
  input  logic [TAG_W-1:0] in_tag,
  input  logic [CNT_W-1:0] in_cnt,
  input  logic             fast_err,
  input  logic             late_err,
  output logic             short_push_v,
  output logic [TAG_W-1:0] short_push_tag,
  output logic [CNT_W-1:0] short_push_cnt,
  output logic             long_push_v,
  output logic [TAG_W-1:0] long_push_tag,
  output logic [CNT_W-1:0] long_push_cnt,
  output logic             retire_v,
  output logic [TAG_W-1:0] retire_tag,
  output logic [CNT_W-1:0] retire_cnt
);

  localparam bit SINGLE = (SINGLE_LOOP != 0);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (c == {CNT_W{1'b1}}) ? c : c + 1'b1;
  endfunction

  logic [LATE_STG:1] vld_q;
  logic [LATE_STG:1] ferr_q;
  logic [TAG_W-1:0]  tag_q [1:LATE_STG];
  logic [CNT_W-1:0]  cnt_q [1:LATE_STG];

  logic fast_hit, fast_divert, fast_mark, late_hit;

  assign fast_hit    = vld_q[FAST_STG] & fast_err;
  assign fast_divert = fast_hit & ~SINGLE;
  assign fast_mark   = fast_hit & SINGLE;
  assign late_hit    = vld_q[LATE_STG] & (late_err | ferr_q[LATE_STG]);

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else begin
      vld_q[1] <= in_v;
      for (int k = 1; k < LATE_STG; k++)
        vld_q[k+1] <= vld_q[k] & ~((k == FAST_STG) & fast_divert);
    end
    tag_q[1]  <= in_tag;
    cnt_q[1]  <= in_cnt;
    ferr_q[1] <= 1'b0;
    for (int k = 1; k < LATE_STG; k++) begin
      tag_q[k+1]  <= tag_q[k];
      cnt_q[k+1]  <= cnt_q[k];
      ferr_q[k+1] <= ferr_q[k] | ((k == FAST_STG) & fast_mark);
    end
  end

  assign short_push_v   = fast_divert;
  assign short_push_tag = tag_q[FAST_STG];
  assign short_push_cnt = sat_inc(cnt_q[FAST_STG]);
  assign long_push_v    = late_hit;
  assign long_push_tag  = tag_q[LATE_STG];
  assign long_push_cnt  = sat_inc(cnt_q[LATE_STG]);
  assign retire_v       = vld_q[LATE_STG] & ~late_hit;
  assign retire_tag     = tag_q[LATE_STG];
  assign retire_cnt     = cnt_q[LATE_STG];

endmodule

// File: rtl/uop_replay_arb.sv
module uop_replay_arb
  import uop_replay_pkg::*;
#(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         long_v,
  input  logic [W-1:0] long_d,
  input  logic         short_v,
  input  logic [W-1:0] short_d,
  input  logic         new_v,
  input  logic [W-1:0] new_d,
  output logic         out_v,
  output logic [W-1:0] out_d,
  output logic         new_ready,
  output disp_src_e    src,
  output logic         skid_full,
  output logic         skid_ovf
);

  logic         skid_v_q;
  logic [W-1:0] skid_d_q;
  logic         skid_v_n;
  logic [W-1:0] skid_d_n;

  always_comb begin
    if (long_v)         begin src = SRC_LONG;  out_d = long_d;   end
    else if (skid_v_q)  begin src = SRC_SKID;  out_d = skid_d_q; end
    else if (short_v)   begin src = SRC_SHORT; out_d = short_d;  end
    else                begin src = SRC_NEW;   out_d = new_d;    end
  end

  assign new_ready = (src == SRC_NEW);
  assign out_v     = ~new_ready | new_v;
  assign skid_full = skid_v_q;
  assign skid_ovf  = long_v & skid_v_q & short_v;

  always_comb begin
    skid_v_n = 1'b0;
    skid_d_n = skid_d_q;
    unique case (src)
      SRC_LONG: begin
        if (skid_v_q)     skid_v_n = 1'b1;
        else if (short_v) begin skid_v_n = 1'b1; skid_d_n = short_d; end
      end
      SRC_SKID: begin
        if (short_v) begin skid_v_n = 1'b1; skid_d_n = short_d; end
      end
      default: skid_v_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) skid_v_q <= 1'b0;
    else     skid_v_q <= skid_v_n;
    skid_d_q <= skid_d_n;
  end

endmodule

// File: rtl/uop_replay_loop.sv
module uop_replay_loop
  import uop_replay_pkg::*;
#(
  parameter int TAG_W       = 8,
  parameter int CNT_W       = 3,
  parameter int FAST_STG    = 2,
  parameter int LATE_STG    = 4,
  parameter int SHORT_LAT   = 7,
  parameter int LONG_LAT    = 12,
  parameter int SINGLE_LAT  = 18,
  parameter int SINGLE_LOOP = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             new_valid,
  input  logic [TAG_W-1:0] new_tag,
  output logic             new_ready,
  input  logic             fast_err,
  input  logic             late_err,
  output logic             disp_valid,
  output logic [TAG_W-1:0] disp_tag,
  output logic [CNT_W-1:0] disp_cnt,
  output logic             retire_valid,
  output logic [TAG_W-1:0] retire_tag,
  output logic [CNT_W-1:0] retire_cnt
);

  localparam int UW          = TAG_W + CNT_W;
  localparam int SHORT_DEPTH = line_depth(SHORT_LAT, FAST_STG);
  localparam int LONG_DEPTH  = (SINGLE_LOOP != 0) ? line_depth(SINGLE_LAT, LATE_STG)
                                                  : line_depth(LONG_LAT, LATE_STG);

  logic             short_push_v, long_push_v;
  logic [TAG_W-1:0] short_push_tag, long_push_tag;
  logic [CNT_W-1:0] short_push_cnt, long_push_cnt;
  logic             short_arrive, long_arrive;
  logic [UW-1:0]    short_ret_d, long_ret_d, disp_d;
  disp_src_e        disp_src;
  logic             skid_full, skid_ovf;

  uop_check_pipe #(
    .TAG_W(TAG_W), .CNT_W(CNT_W), .FAST_STG(FAST_STG),
    .LATE_STG(LATE_STG), .SINGLE_LOOP(SINGLE_LOOP)
  ) pipe_i (
    .clk(clk), .rst(rst),
    .in_v(disp_valid), .in_tag(disp_tag), .in_cnt(disp_cnt),
    .fast_err(fast_err), .late_err(late_err),
    .short_push_v(short_push_v), .short_push_tag(short_push_tag), .short_push_cnt(short_push_cnt),
    .long_push_v(long_push_v), .long_push_tag(long_push_tag), .long_push_cnt(long_push_cnt),
    .retire_v(retire_valid), .retire_tag(retire_tag), .retire_cnt(retire_cnt)
  );

  generate
    if (SINGLE_LOOP == 0) begin : g_short
      uop_delay_line #(.DEPTH(SHORT_DEPTH), .W(UW)) short_i (
        .clk(clk), .rst(rst),
        .in_v(short_push_v), .in_d({short_push_tag, short_push_cnt}),
        .out_v(short_arrive), .out_d(short_ret_d)
      );
    end else begin : g_no_short
      assign short_arrive = 1'b0;
      assign short_ret_d  = '0;
    end
  endgenerate

  uop_delay_line #(.DEPTH(LONG_DEPTH), .W(UW)) long_i (
    .clk(clk), .rst(rst),
    .in_v(long_push_v), .in_d({long_push_tag, long_push_cnt}),
    .out_v(long_arrive), .out_d(long_ret_d)
  );

  uop_replay_arb #(.W(UW)) arb_i (
    .clk(clk), .rst(rst),
    .long_v(long_arrive), .long_d(long_ret_d),
    .short_v(short_arrive), .short_d(short_ret_d),
    .new_v(new_valid), .new_d({new_tag, {CNT_W{1'b0}}}),
    .out_v(disp_valid), .out_d(disp_d),
    .new_ready(new_ready), .src(disp_src),
    .skid_full(skid_full), .skid_ovf(skid_ovf)
  );

  assign disp_tag = disp_d[UW-1:CNT_W];
  assign disp_cnt = disp_d[CNT_W-1:0];

endmodule

// File: rtl/uop_replay_loop_chk.sv
module uop_replay_loop_chk
  import uop_replay_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             disp_valid,
  input logic             new_ready,
  input logic [1:0]       src,
  input logic             long_arrive,
  input logic             short_arrive,
  input logic             skid_full,
  input logic             skid_ovf,
  input logic             long_push_v,
  input logic [CNT_W-1:0] long_push_cnt,
  input logic             retire_valid
);

  // R6: a pending replay always owns the dispatch slot
  assert_replay_blocks_issue_R6: assert property (@(posedge clk) disable iff (rst)
    (long_arrive || short_arrive || skid_full) |-> (!new_ready && disp_valid));

  // R7: long loop wins a collision
  assert_long_first_R7: assert property (@(posedge clk) disable iff (rst)
    long_arrive |-> (src == SRC_LONG));

  // R7: the losing short-loop micro-op is held for the next cycle
  assert_collision_held_R7: assert property (@(posedge clk) disable iff (rst)
    (long_arrive && short_arrive) |=> skid_full);

  // R7: the single skid entry is never asked to hold two
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    !skid_ovf);

  // R3: a micro-op entering the long loop is not also retired
  assert_no_retire_on_reject_R3: assert property (@(posedge clk) disable iff (rst)
    retire_valid |-> !long_push_v);

  // R8: a rejected micro-op never wraps its count back to zero
  assert_count_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
    long_push_v |-> (long_push_cnt != '0));

  // R9: reset empties both loops and the skid register
  assert_reset_clears_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!long_arrive && !short_arrive && !skid_full));

endmodule

bind uop_replay_loop uop_replay_loop_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .disp_valid(disp_valid), .new_ready(new_ready),
  .src(disp_src), .long_arrive(long_arrive), .short_arrive(short_arrive),
  .skid_full(skid_full), .skid_ovf(skid_ovf), .long_push_v(long_push_v),
  .long_push_cnt(long_push_cnt), .retire_valid(retire_valid)
);

// File: tb/uop_replay_loop_tb_top.sv
module uop_replay_loop_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TAG_W  = 8;
  localparam int CNT_W  = 3;
  localparam int FSTG   = 2;
  localparam int LSTG   = 4;
  localparam int NC     = 1400;
  localparam int NS     = NC + 40;
  localparam int STICKY = 3;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst;
  logic [1:0] new_valid, new_ready, fast_err, late_err, disp_valid, retire_valid;
  logic [TAG_W-1:0] new_tag [2];
  logic [TAG_W-1:0] disp_tag [2];
  logic [TAG_W-1:0] retire_tag [2];
  logic [CNT_W-1:0] disp_cnt [2];
  logic [CNT_W-1:0] retire_cnt [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  uop_replay_loop #(.TAG_W(TAG_W), .CNT_W(CNT_W), .SINGLE_LOOP(0)) dut_i (
    .clk(clk), .rst(rst), .new_valid(new_valid[0]), .new_tag(new_tag[0]),
    .new_ready(new_ready[0]), .fast_err(fast_err[0]), .late_err(late_err[0]),
    .disp_valid(disp_valid[0]), .disp_tag(disp_tag[0]), .disp_cnt(disp_cnt[0]),
    .retire_valid(retire_valid[0]), .retire_tag(retire_tag[0]), .retire_cnt(retire_cnt[0])
  );

  uop_replay_loop #(.TAG_W(TAG_W), .CNT_W(CNT_W), .SINGLE_LOOP(1)) dut_single_i (
    .clk(clk), .rst(rst), .new_valid(new_valid[1]), .new_tag(new_tag[1]),
    .new_ready(new_ready[1]), .fast_err(fast_err[1]), .late_err(late_err[1]),
    .disp_valid(disp_valid[1]), .disp_tag(disp_tag[1]), .disp_cnt(disp_cnt[1]),
    .retire_valid(retire_valid[1]), .retire_tag(retire_tag[1]), .retire_cnt(retire_cnt[1])
  );

  // behavioural model: per-cycle schedules of returns and dispatch records
  bit sv [2][NS];  int stg [2][NS];  int scn [2][NS];
  bit lv [2][NS];  int ltg [2][NS];  int lcn [2][NS];
  bit dv [2][NS];  int dtg [2][NS];  int dcn [2][NS];
  bit dff [2][NS]; bit dlf [2][NS];
  bit skv [2];     int sktg [2];     int skcn [2];
  int next_tag [2];
  int cyc;
  int n_chk = 0, n_fail = 0;
  int collisions = 0, saturations = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic int sat(input int c);
    return (c >= CMAX) ? CMAX : c + 1;
  endfunction

  function automatic int arrivals(input int m, input int y);
    return int'(sv[m][y]) + int'(lv[m][y]);
  endfunction

  // a new return at x must not make a double arrival followed by another one
  function automatic bit slot_ok(input int m, input int x);
    int c0, c1, c2;
    c0 = arrivals(m, x - 1);
    c1 = arrivals(m, x) + 1;
    c2 = arrivals(m, x + 1);
    return !((c0 == 2 && c1 >= 1) || (c1 == 2 && c2 >= 1) || c1 > 2);
  endfunction

  task automatic clear_model();
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < NS; i++) begin
        sv[m][i] = 0; lv[m][i] = 0; dv[m][i] = 0; dff[m][i] = 0; dlf[m][i] = 0;
      end
      skv[m] = 0;
    end
  endtask

  task automatic plan_cycle(input int m);
    int d, x;
    bit want;
    new_valid[m] = ($urandom % 10) < 6;
    new_tag[m]   = TAG_W'(next_tag[m]);
    // fast check stage
    d = cyc - FSTG;
    fast_err[m] = 1'b0;
    if (d >= 0 && dv[m][d]) begin
      want = (dtg[m][d] == STICKY) || (($urandom % 100) < 15);
      x = d + ((m == 1) ? 18 : 7);
      if (want && slot_ok(m, x)) begin
        fast_err[m] = 1'b1;
        dff[m][d] = 1;
        if (m == 1) begin lv[m][x] = 1; ltg[m][x] = dtg[m][d]; lcn[m][x] = sat(dcn[m][d]); end
        else        begin sv[m][x] = 1; stg[m][x] = dtg[m][d]; scn[m][x] = sat(dcn[m][d]); end
      end
    end else fast_err[m] = 1'($urandom % 2);   // R3: no live micro-op, must be ignored
    // late check stage
    d = cyc - LSTG;
    late_err[m] = 1'b0;
    if (d >= 0 && dv[m][d] && !dff[m][d]) begin
      want = (dtg[m][d] == STICKY) || (($urandom % 100) < 15);
      x = d + ((m == 1) ? 18 : 12);
      if (want && slot_ok(m, x)) begin
        late_err[m] = 1'b1;
        dlf[m][d] = 1;
        lv[m][x] = 1; ltg[m][x] = dtg[m][d]; lcn[m][x] = sat(dcn[m][d]);
      end
    end else late_err[m] = 1'($urandom % 2);   // R3: already diverted or empty stage
  endtask

  task automatic compare_commit(input int m);
    int src, ev, et, ec, d;
    string req;
    if (lv[m][cyc])      begin src = 2; et = ltg[m][cyc]; ec = lcn[m][cyc]; req = (m == 1) ? "R4" : "R2"; end
    else if (skv[m])     begin src = 3; et = sktg[m];     ec = skcn[m];     req = "R7"; end
    else if (sv[m][cyc]) begin src = 1; et = stg[m][cyc]; ec = scn[m][cyc]; req = "R1"; end
    else                 begin src = 0; et = next_tag[m] % (1 << TAG_W); ec = 0; req = "R6"; end
    ev = (src != 0) || new_valid[m];
    if (lv[m][cyc] && sv[m][cyc]) collisions++;
    check("R6", "new_ready", int'(new_ready[m]), int'(src == 0));
    check(req, "disp_valid", int'(disp_valid[m]), ev);
    if (ev) begin
      check(req, "disp_tag", int'(disp_tag[m]), et);
      check("R8", "disp_cnt", int'(disp_cnt[m]), ec);
      if (ec == CMAX) saturations++;
    end
    d = cyc - LSTG;
    ev = (d >= 0 && dv[m][d] && !dff[m][d] && !dlf[m][d]);
    check("R3", "retire_valid", int'(retire_valid[m]), ev);
    if (ev) begin
      check("R5", "retire_tag", int'(retire_tag[m]), dtg[m][d]);
      check("R5", "retire_cnt", int'(retire_cnt[m]), dcn[m][d]);
    end
    // commit the skid register and the dispatch record
    if (src == 2) begin
      if (!skv[m] && sv[m][cyc]) begin skv[m] = 1; sktg[m] = stg[m][cyc]; skcn[m] = scn[m][cyc]; end
    end else if (src == 3) begin
      if (sv[m][cyc]) begin sktg[m] = stg[m][cyc]; skcn[m] = scn[m][cyc]; end
      else skv[m] = 0;
    end
    dv[m][cyc]  = (src != 0) || new_valid[m];
    dtg[m][cyc] = et;
    dcn[m][cyc] = ec;
    dff[m][cyc] = 0;
    dlf[m][cyc] = 0;
    if (src == 0 && new_valid[m]) next_tag[m] = next_tag[m] + 1;
  endtask

  task automatic run_cycles(input int n);
    for (int k = 0; k < n; k++) begin
      plan_cycle(0);
      plan_cycle(1);
      #1;
      compare_commit(0);
      compare_commit(1);
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic reset_and_check();
    rst = 1'b1;
    new_valid = '0; fast_err = '0; late_err = '0;
    new_tag[0] = '0; new_tag[1] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    clear_model();
    #1;
    for (int m = 0; m < 2; m++) begin
      check("R9", "disp_valid after reset", int'(disp_valid[m]), 0);
      check("R9", "retire_valid after reset", int'(retire_valid[m]), 0);
      check("R9", "new_ready after reset", int'(new_ready[m]), 1);
    end
    @(negedge clk);
    cyc = 1;
  endtask

  initial begin
    next_tag[0] = 0;
    next_tag[1] = 0;
    cyc = 0;
    @(negedge clk);
    reset_and_check();
    run_cycles(NC - 30);
    // reset with micro-ops still in flight in both loops
    reset_and_check();
    run_cycles(NC - 30);
    if (collisions == 0) check("R7", "loop collisions seen", collisions, 1);
    if (saturations == 0) check("R8", "saturated counts seen", saturations, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 2 * NC);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule